// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block turns a stream of internal transfer requests into processor bus cycles. Each request carries a word address, byte enables and four type flags: write, data (as opposed to control), memory (as opposed to I/O) and locked. For each request it drives a one-clock address strobe together with the address and type outputs. It then waits in a data phase until the external ready input ends the cycle. When a read ends, the sampled read data comes out on a one-clock response pulse.

The sequencer supports address pipelining. If the system raises the next-address input during a data phase, the sequencer may strobe the following request's address and type while the current cycle is still waiting for ready. If no request is waiting at that moment, the sequencer remembers the grant and strobes the next request as soon as it arrives. A bus lock output covers every cycle of a locked sequence. It follows the cycle that occupies the data phase, so under pipelining it rises later than the strobe.

The request side is valid/ready:
- `req_ready` is a function of the sequencer state and the two bus inputs, never of `req_valid`.
- A requester must hold the request fields stable while `req_valid` is high and `req_ready` is low.
- A transfer happens on a rising edge where both are high.

The response side has no back-pressure. `rsp_valid` is a single-cycle pulse that must be taken when it appears.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after reset the outputs are: strobe low, lock low, write low, data flag high, memory flag low, address and byte enables zero, `rsp_valid` low. In this state `req_ready` is high.
- R2: `req_ready` is high in these situations:
  - when idle;
  - in a data-phase clock where ready or next-address is high;
  - while a next-address grant is held with no request.
  It is low in the first state of any cycle and while a pipelined address is waiting for the older cycle to end.
- R3: An accepted legal request raises `bus_strobe` for exactly one clock after the accepting edge. The address, byte enables and type flags take the request's values at that same edge and hold them until the next strobe.
- R4: Ready is ignored in the first state of every cycle, whether that cycle was started normally or pipelined. A high ready there neither ends a cycle nor produces a response.
- R5: Ready sampled high in a data-phase state ends the current cycle. For a read, `rsp_valid` is high in the following clock, with `rsp_data` equal to `bus_rdata` at the ending edge. A write ends with no response.
- R6: Suppose next-address is high, ready is low, and a legal request is offered in a data-phase clock. Then the request is strobed at that edge while the older cycle continues. The next ready ends the older cycle, and the pipelined cycle enters its first state.
- R7: Suppose next-address is high with no request offered. The grant is held. A request arriving before ready is strobed at once as a pipelined cycle. If ready arrives first, the cycle ends and a request offered with that ready starts a normal cycle.
- R8: `bus_lock` is the lock flag of the cycle currently in its bus states. It rises together with the strobe for a normal start. For a pipelined start it rises at the edge where ready ends the previous cycle. It falls at the edge where ready ends a locked cycle and no locked cycle follows.
- R9: The type combination memory=0, data=0, write=1 is never strobed. A request with that combination is accepted and discarded, and the bus outputs keep their values.
- R10: There is no timeout. A cycle stays in its data phase for as many clocks as ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock, one bus state per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | AW | Word address of the request |
| req_be | input | BEW | Byte enables of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data cycle, 0 = control cycle |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_lock | input | 1 | Cycle belongs to a locked sequence |
| bus_strobe | output | 1 | Address strobe, one clock per started cycle |
| bus_addr | output | AW | Address on the bus |
| bus_be | output | BEW | Byte enables on the bus |
| bus_wr | output | 1 | Bus write flag |
| bus_data | output | 1 | Bus data/control flag |
| bus_mem | output | 1 | Bus memory/I/O flag |
| bus_lock | output | 1 | Bus lock |
| bus_rdy | input | 1 | Cycle end acknowledge |
| bus_nxt | input | 1 | System accepts the next address early |
| bus_rdata | input | DW | Read data from the bus |
| rsp_valid | output | 1 | Read data pulse |
| rsp_data | output | DW | Read data captured at the cycle end |

## Verification
Several rules are checked on every clock:
- the strobe lasts one clock;
- the bus address and type stay frozen between strobes;
- the forbidden type never appears with the strobe;
- no response follows a first-state clock;
- every response and every lock edge is preceded by a ready, except a lock rise that coincides with a strobe;
- requests are refused in the first and pipelined-wait states.

Other behaviours need the bench's scenarios:
- the order and content of strobed requests against those accepted;
- read data matching the value present at the ending edge;
- lock moving one ready later than the strobe under pipelining;
- the two ways out of a held next-address grant;
- arbitrarily long wait states.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Bus states: first state and data phase of a normal cycle, first state of a
  // pipelined cycle, data phase with the next address already strobed, and
  // data phase with an early-address grant but no request yet.
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T1P  = 3'd3,
    S_T2P  = 3'd4,
    S_T2I  = 3'd5
  } bus_state_t;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_legal,
  input  logic       bus_rdy,
  input  logic       bus_nxt,
  output logic       req_ready,
  output logic       launch,
  output logic       begin_np,
  output logic       begin_p,
  output logic       cyc_end,
  output bus_state_t state
);
  bus_state_t nxt_st;
  logic       in_data;

  assign in_data = (state == S_T2) || (state == S_T2I) || (state == S_T2P);

  always_comb begin
    case (state)
      S_IDLE:  req_ready = 1'b1;
      S_T2:    req_ready = bus_rdy | bus_nxt;
      S_T2I:   req_ready = 1'b1;
      default: req_ready = 1'b0;
    endcase
  end

  assign launch = req_valid & req_ready & req_legal;

  always_comb begin
    nxt_st = state;
    case (state)
      S_IDLE: begin
        if (launch) nxt_st = S_T1;
      end
      S_T1:  nxt_st = S_T2;
      S_T1P: nxt_st = S_T2;
      S_T2: begin
        if (bus_rdy)      nxt_st = launch ? S_T1 : S_IDLE;
        else if (bus_nxt) nxt_st = launch ? S_T2P : S_T2I;
      end
      S_T2I: begin
        if (bus_rdy)     nxt_st = launch ? S_T1 : S_IDLE;
        else if (launch) nxt_st = S_T2P;
      end
      S_T2P: begin
        if (bus_rdy) nxt_st = S_T1P;
      end
      default: nxt_st = S_IDLE;
    endcase
  end

  assign cyc_end  = bus_rdy & in_data;
  assign begin_np = launch & (nxt_st == S_T1);
  assign begin_p  = bus_rdy & (state == S_T2P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt_st;
  end
endmodule

// File: rtl/bcs_addr_stage.sv
module bcs_addr_stage #(
  parameter int AW  = 30,
  parameter int BEW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic [AW-1:0]  req_addr,
  input  logic [BEW-1:0] req_be,
  input  logic           req_wr,
  input  logic           req_data,
  input  logic           req_mem,
  input  logic           req_lock,
  output logic           bus_strobe,
  output logic [AW-1:0]  bus_addr,
  output logic [BEW-1:0] bus_be,
  output logic           bus_wr,
  output logic           bus_data,
  output logic           bus_mem,
  output logic           pend_lock
);
  // Address and type registers load only on a launch and hold otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_strobe <= 1'b0;
      bus_addr   <= '0;
      bus_be     <= '0;
      bus_wr     <= 1'b0;
      bus_data   <= 1'b1;
      bus_mem    <= 1'b0;
      pend_lock  <= 1'b0;
    end else begin
      bus_strobe <= launch;
      if (launch) begin
        bus_addr  <= req_addr;
        bus_be    <= req_be;
        bus_wr    <= req_wr;
        bus_data  <= req_data;
        bus_mem   <= req_mem;
        pend_lock <= req_lock;
      end
    end
  end
endmodule

// File: rtl/bcs_data_stage.sv
module bcs_data_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          begin_np,
  input  logic          begin_p,
  input  logic          cyc_end,
  input  logic          req_wr,
  input  logic          req_lock,
  input  logic          pend_wr,
  input  logic          pend_lock,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_lock,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic cur_wr;
  logic cur_lock;
  logic rd_end;

  assign rd_end   = cyc_end & ~cur_wr;
  assign bus_lock = cur_lock;

  // Tracks the cycle that owns the bus states, which under pipelining lags
  // the address registers by one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wr    <= 1'b0;
      cur_lock  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_end;
      if (rd_end) rsp_data <= bus_rdata;
      if (begin_np) begin
        cur_wr   <= req_wr;
        cur_lock <= req_lock;
      end else if (begin_p) begin
        cur_wr   <= pend_wr;
        cur_lock <= pend_lock;
      end else if (cyc_end) begin
        cur_lock <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [BEW-1:0] req_be,
  input  logic           req_wr,
  input  logic           req_data,
  input  logic           req_mem,
  input  logic           req_lock,
  output logic           bus_strobe,
  output logic [AW-1:0]  bus_addr,
  output logic [BEW-1:0] bus_be,
  output logic           bus_wr,
  output logic           bus_data,
  output logic           bus_mem,
  output logic           bus_lock,
  input  logic           bus_rdy,
  input  logic           bus_nxt,
  input  logic [DW-1:0]  bus_rdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data
);
  bus_state_t st;
  logic req_legal, launch, begin_np, begin_p, cyc_end, pend_lock;

  // I/O + control + write is a reserved type and is never issued.
  assign req_legal = ~(~req_mem & ~req_data & req_wr);

  bcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(req_legal),
    .bus_rdy(bus_rdy), .bus_nxt(bus_nxt), .req_ready(req_ready),
    .launch(launch), .begin_np(begin_np), .begin_p(begin_p),
    .cyc_end(cyc_end), .state(st)
  );

  bcs_addr_stage #(.AW(AW), .BEW(BEW)) u_addr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .req_addr(req_addr),
    .req_be(req_be), .req_wr(req_wr), .req_data(req_data), .req_mem(req_mem),
    .req_lock(req_lock), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_data(bus_data), .bus_mem(bus_mem),
    .pend_lock(pend_lock)
  );

  bcs_data_stage #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .begin_np(begin_np), .begin_p(begin_p),
    .cyc_end(cyc_end), .req_wr(req_wr), .req_lock(req_lock),
    .pend_wr(bus_wr), .pend_lock(pend_lock), .bus_rdata(bus_rdata),
    .bus_lock(bus_lock), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk
  import bcs_pkg::*;
#(
  parameter int AW  = 30,
  parameter int BEW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input bus_state_t     st,
  input logic           req_ready,
  input logic           bus_strobe,
  input logic [AW-1:0]  bus_addr,
  input logic [BEW-1:0] bus_be,
  input logic           bus_wr,
  input logic           bus_data,
  input logic           bus_mem,
  input logic           bus_lock,
  input logic           bus_rdy,
  input logic           rsp_valid
);
  // R3
  strobe_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> !bus_strobe);

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> $stable({bus_addr, bus_be, bus_wr, bus_data, bus_mem}));

  // R9
  no_reserved_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> !(!bus_mem && !bus_data && bus_wr));

  // R4
  first_state_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1 || st == S_T1P) |=> !rsp_valid);

  // R5
  rsp_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_rdy));

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(bus_rdy));

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> (bus_strobe || $past(bus_rdy)));

  // R2
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1 || st == S_T1P || st == S_T2P) |-> !req_ready);
endmodule

bind bus_cycle_seq bcs_chk #(.AW(AW), .BEW(BEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .req_ready(req_ready),
  .bus_strobe(bus_strobe), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wr(bus_wr), .bus_data(bus_data), .bus_mem(bus_mem),
  .bus_lock(bus_lock), .bus_rdy(bus_rdy), .rsp_valid(rsp_valid)
);

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  localparam int AW  = 30;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;
  localparam int QW  = AW + BEW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           req_valid = 0, req_ready;
  logic [AW-1:0]  req_addr = '0;
  logic [BEW-1:0] req_be = '0;
  logic           req_wr = 0, req_data = 0, req_mem = 0, req_lock = 0;
  logic           bus_strobe, bus_wr, bus_data, bus_mem, bus_lock;
  logic [AW-1:0]  bus_addr;
  logic [BEW-1:0] bus_be;
  logic           bus_rdy = 0, bus_nxt = 0;
  logic [DW-1:0]  bus_rdata = '0;
  logic           rsp_valid;
  logic [DW-1:0]  rsp_data;

  bus_cycle_seq #(.AW(AW), .DW(DW)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit acc;
  bit done = 0;
  logic [QW-1:0] exp_q[$];
  logic [DW-1:0] smp_rdata;
  int reads_out = 0, rsp_seen = 0;

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input bit m, input bit d, input bit w);
    return !(!m && !d && w);
  endfunction

  task automatic step();
    #1;
    acc = req_valid && req_ready;
    smp_rdata = bus_rdata;
    @(posedge clk);
    #1;
  endtask

  task automatic set_req(input bit v, input logic [AW-1:0] a, input logic [BEW-1:0] be,
                         input bit w, input bit d, input bit m, input bit lk);
    req_valid = v; req_addr = a; req_be = be;
    req_wr = w; req_data = d; req_mem = m; req_lock = lk;
  endtask

  // random-phase scoreboard step
  task automatic rstep();
    step();
    if (acc && legal(req_mem, req_data, req_wr))
      exp_q.push_back({req_addr, req_be, req_wr, req_data, req_mem});
    if (bus_strobe) begin
      if (exp_q.size() == 0) chk_eq("R3 unexpected strobe", 1, 0);
      else begin
        logic [QW-1:0] e;
        e = exp_q.pop_front();
        chk_eq("R3 strobed request content",
               {bus_addr, bus_be, bus_wr, bus_data, bus_mem}, e);
        if (!bus_wr) reads_out++;
      end
    end
    if (rsp_valid) begin
      rsp_seen++;
      chk_eq("R5 read data", rsp_data, smp_rdata);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk_eq("R1 strobe", bus_strobe, 0);
    chk_eq("R1 lock", bus_lock, 0);
    chk_eq("R1 type wr/data/mem", {bus_wr, bus_data, bus_mem}, 3'b010);
    chk_eq("R1 addr/be", {bus_addr, bus_be}, 0);
    chk_eq("R1 rsp_valid", rsp_valid, 0);
    chk_eq("R1 req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Normal read, ready ignored in first state
    set_req(1, 30'h1234, 4'hF, 0, 1, 1, 0);
    #1 chk_eq("R2 ready when idle", req_ready, 1);
    step();
    chk_eq("R2 accepted", acc, 1);
    chk_eq("R3 strobe on launch", bus_strobe, 1);
    chk_eq("R3 address", bus_addr, 30'h1234);
    chk_eq("R8 unlocked", bus_lock, 0);
    req_valid = 0; bus_rdy = 1; bus_rdata = 32'hAAAA0001;
    #1 chk_eq("R2 refused in first state", req_ready, 0);
    step();
    chk_eq("R4 ready ignored in T1", rsp_valid, 0);
    chk_eq("R3 strobe one clock", bus_strobe, 0);
    chk_eq("R3 address held", bus_addr, 30'h1234);
    bus_rdata = 32'hBEEF0002;
    step();
    chk_eq("R5 read response", rsp_valid, 1);
    chk_eq("R5 read data", rsp_data, 32'hBEEF0002);
    bus_rdy = 0;
    step();
    chk_eq("R5 response one clock", rsp_valid, 0);

    // Write with long wait
    set_req(1, 30'h2000, 4'h3, 1, 1, 1, 0);
    step();
    req_valid = 0;
    step();
    for (int i = 0; i < 6; i++) begin
      step();
      chk_eq("R10 still waiting", req_ready, 0);
    end
    bus_rdy = 1;
    step();
    chk_eq("R5 write gives no response", rsp_valid, 0);
    bus_rdy = 0;
    #1 chk_eq("R10 ends only on ready", req_ready, 1);

    // Pipelined locked write behind a read
    set_req(1, 30'h3000, 4'hF, 0, 1, 1, 0);
    step();
    req_valid = 0;
    step();
    bus_nxt = 1;
    set_req(1, 30'h3004, 4'hF, 1, 1, 1, 1);
    #1 chk_eq("R2 ready on next-address", req_ready, 1);
    step();
    chk_eq("R6 pipelined strobe", bus_strobe, 1);
    chk_eq("R6 pipelined address", bus_addr, 30'h3004);
    chk_eq("R8 lock waits for data phase", bus_lock, 0);
    req_valid = 0; bus_nxt = 0;
    step();
    bus_rdy = 1; bus_rdata = 32'h0C0FFEE3;
    #1 chk_eq("R2 refused while pipelined", req_ready, 0);
    step();
    chk_eq("R6 older read ends", rsp_valid, 1);
    chk_eq("R6 older read data", rsp_data, 32'h0C0FFEE3);
    chk_eq("R8 lock rises at pipelined start", bus_lock, 1);
    step();
    chk_eq("R4 ready ignored in T1P", rsp_valid, 0);
    chk_eq("R8 lock held", bus_lock, 1);
    step();
    chk_eq("R8 lock released after last locked", bus_lock, 0);
    bus_rdy = 0;
    step();

    // Grant held, request arrives before ready
    set_req(1, 30'h4000, 4'h1, 0, 1, 1, 0);
    step();
    req_valid = 0;
    step();
    bus_nxt = 1;
    step();
    chk_eq("R7 no strobe without request", bus_strobe, 0);
    bus_nxt = 0;
    set_req(1, 30'h4008, 4'h2, 0, 1, 1, 0);
    #1 chk_eq("R7 grant held", req_ready, 1);
    step();
    chk_eq("R7 late pipelined strobe", bus_strobe, 1);
    chk_eq("R7 late pipelined address", bus_addr, 30'h4008);
    req_valid = 0; bus_rdy = 1; bus_rdata = 32'h44;
    step();
    chk_eq("R7 older read data", rsp_data, 32'h44);
    bus_rdy = 0;
    step();
    bus_rdy = 1; bus_rdata = 32'h55;
    step();
    chk_eq("R7 pipelined read data", {rsp_valid, rsp_data}, {1'b1, 32'h55});
    bus_rdy = 0;
    step();

    // Grant held, ready arrives first with a locked request
    set_req(1, 30'h5000, 4'hF, 0, 1, 1, 0);
    step();
    req_valid = 0;
    step();
    bus_nxt = 1;
    step();
    bus_nxt = 0; bus_rdy = 1; bus_rdata = 32'h66;
    set_req(1, 30'h5010, 4'hF, 0, 1, 1, 1);
    step();
    chk_eq("R7 normal start after ready", bus_strobe, 1);
    chk_eq("R7 old cycle ended", rsp_valid, 1);
    chk_eq("R8 lock with strobe", bus_lock, 1);
    req_valid = 0;
    step();
    step();
    chk_eq("R8 lock dropped", bus_lock, 0);
    bus_rdy = 0;
    step();

    // Reserved type
    set_req(1, 30'h0BAD, 4'hF, 1, 0, 0, 0);
    #1 chk_eq("R9 reserved accepted", req_ready, 1);
    step();
    chk_eq("R9 consumed", acc, 1);
    chk_eq("R9 no strobe", bus_strobe, 0);
    chk_eq("R9 bus unchanged", bus_addr, 30'h5010);
    req_valid = 0;
    step();
    chk_eq("R9 still idle", req_ready, 1);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      if (!req_valid || acc)
        set_req($urandom % 3 != 0, AW'($urandom), BEW'($urandom), $urandom % 2,
                $urandom % 2, $urandom % 2, $urandom % 4 == 0);
      bus_rdy = ($urandom % 3 == 0);
      bus_nxt = $urandom % 2;
      bus_rdata = $urandom;
      rstep();
    end
    req_valid = 0; bus_nxt = 0; bus_rdy = 1;
    for (int i = 0; i < 12; i++) rstep();
    chk_eq("R3 all accepted requests strobed", exp_q.size(), 0);
    chk_eq("R5 one response per read", rsp_seen, reads_out);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule